// File: doc/BRIEF.md
# Nested Counted-Loop Fetch Sequencer

This block steers instruction fetch through hardware-counted loops at two nesting depths. Each depth keeps a loop-start address and a remaining-pass count. A single load command writes both values for the depth it selects. Software then runs the loop body with no branch instruction at its end. Instead, the fetch stage marks the last packet of each body with a per-depth end flag.

On every valid fetched packet the sequencer looks at the end flags and the stored counts. It then picks the next fetch address in the same cycle: the inner start, the outer start, or the sequential address that the fetch stage supplies. The affected count changes on the following clock edge. Looping back therefore costs no idle fetch cycles and needs no predictor. Both depths can be read back through a select input, so that an interrupt handler can save and restore loop context.

Top module: `hwloop_ctrl`

## Requirements
- R1: After a synchronous active-low reset, both counts and both start addresses read back as zero, and an end flag then yields the sequential address.
- R2: With `ld_valid` high, the start and count on `ld_start`/`ld_count` are stored at the next clock edge for depth `ld_depth` (0 = inner, 1 = outer). The other depth is left unchanged. Values read back on `rb_start`/`rb_count` for the depth chosen by `rb_depth`.
- R3: A valid packet with `end_in` set while the inner count is above one drives `next_addr` to the inner start in that same cycle. The inner count drops by one at the next edge.
- R4: A valid packet with `end_in` set while the inner count is one drives `next_addr` to `seq_addr`. The inner count becomes zero.
- R5: A count loaded as zero gives a single pass: the first inner end flag falls through to `seq_addr` and the count stays zero.
- R6: A valid packet with only `end_out` set applies the same rules to the outer depth. The outer count decrements and `next_addr` is the outer start when the count is above one. Otherwise the count clears and fetch falls through.
- R7: When both flags are set and the inner count is above one, only the inner depth acts. The outer count is unchanged.
- R8: When both flags are set and the inner count is one or zero, the inner count clears and the outer depth is evaluated as in R6.
- R9: End flags are ignored while `fetch_valid` is low: `next_addr` equals `seq_addr` and both counts keep their values.
- R10: A load and an end flag hitting the same depth in the same cycle store the loaded count. The address choice in that cycle still uses the old count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | Load command for one depth |
| ld_depth | input | 1 | Depth to load: 0 inner, 1 outer |
| ld_start | input | AW | Loop start address to store |
| ld_count | input | CW | Pass count to store |
| fetch_valid | input | 1 | Current packet is valid |
| end_in | input | 1 | Packet ends the inner loop body |
| end_out | input | 1 | Packet ends the outer loop body |
| seq_addr | input | AW | Sequential address after the current packet |
| next_addr | output | AW | Next fetch address |
| rb_depth | input | 1 | Depth selected for read-back |
| rb_start | output | AW | Stored start of the selected depth |
| rb_count | output | CW | Remaining count of the selected depth |

## Verification
The properties assume that `ld_depth` and the end flags are never unknown. They also assume that a load aimed at a depth makes that depth's decrement checks vacuous, which is why those checks exclude a same-depth load. The directed scenarios drive every input on the falling edge and hold end flags low between packets. Any same-cycle collision of a load and an end flag is created on purpose in the single scenario that targets it. Outer-loop scenarios reload the inner depth before each outer pass, as software would.

// File: rtl/hwloop_pkg.sv
// Shared definitions for the counted-loop sequencer.
package hwloop_pkg;
    localparam int DEPTHS = 2;

    // Source chosen for the next fetch address.
    typedef enum logic [1:0] {
        SRC_SEQ   = 2'd0,
        SRC_INNER = 2'd1,
        SRC_OUTER = 2'd2
    } addr_src_e;
endpackage

// File: rtl/hwloop_depth.sv
// One loop depth: holds start address and remaining count.
// Assumes load has priority over a step in the same cycle.
module hwloop_depth #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_start,
    input  logic [CW-1:0] load_count,
    input  logic          step,
    output logic [AW-1:0] start_q,
    output logic [CW-1:0] count_q,
    output logic          again
);
    localparam logic [CW-1:0] ONE = CW'(1);

    // Another pass remains only while the count is above one.
    always_comb again = (count_q > ONE);

    // Register update: reset, load, or step toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            count_q <= '0;
        end else if (load) begin
            start_q <= load_start;
            count_q <= load_count;
        end else if (step) begin
            count_q <= again ? (count_q - ONE) : '0;
        end
    end
endmodule

// File: rtl/hwloop_arb.sv
// Nesting decision: inner depth first, outer acts only on the inner's last pass.
// Assumes end flags are meaningful only with fetch_valid.
module hwloop_arb
    import hwloop_pkg::*;
(
    input  logic      fetch_valid,
    input  logic      end_in,
    input  logic      end_out,
    input  logic      again_in,
    input  logic      again_out,
    output logic      step_in,
    output logic      step_out,
    output addr_src_e src
);
    // Decide which depths step and where fetch goes.
    always_comb begin
        step_in  = fetch_valid && end_in;
        step_out = fetch_valid && end_out && !(end_in && again_in);
        if (step_in && again_in)
            src = SRC_INNER;
        else if (step_out && again_out)
            src = SRC_OUTER;
        else
            src = SRC_SEQ;
    end
endmodule

// File: rtl/hwloop_ctrl.sv
// Top: two loop depths, nesting arbiter, next-address select and read-back.
// Assumes the fetch stage supplies seq_addr for the current packet.
module hwloop_ctrl
    import hwloop_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_valid,
    input  logic          ld_depth,
    input  logic [AW-1:0] ld_start,
    input  logic [CW-1:0] ld_count,
    input  logic          fetch_valid,
    input  logic          end_in,
    input  logic          end_out,
    input  logic [AW-1:0] seq_addr,
    output logic [AW-1:0] next_addr,
    input  logic          rb_depth,
    output logic [AW-1:0] rb_start,
    output logic [CW-1:0] rb_count
);
    logic [AW-1:0] start_q [DEPTHS];
    logic [CW-1:0] cnt_q   [DEPTHS];
    logic          again   [DEPTHS];
    logic          step    [DEPTHS];
    addr_src_e     src;

    // Instantiate one register set per depth.
    for (genvar d = 0; d < DEPTHS; d++) begin : g_depth
        hwloop_depth #(.AW(AW), .CW(CW)) u_depth (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (ld_valid && (int'(ld_depth) == d)),
            .load_start (ld_start),
            .load_count (ld_count),
            .step       (step[d]),
            .start_q    (start_q[d]),
            .count_q    (cnt_q[d]),
            .again      (again[d])
        );
    end

    hwloop_arb u_arb (
        .fetch_valid (fetch_valid),
        .end_in      (end_in),
        .end_out     (end_out),
        .again_in    (again[0]),
        .again_out   (again[1]),
        .step_in     (step[0]),
        .step_out    (step[1]),
        .src         (src)
    );

    // Next fetch address mux.
    always_comb begin
        unique case (src)
            SRC_INNER: next_addr = start_q[0];
            SRC_OUTER: next_addr = start_q[1];
            default:   next_addr = seq_addr;
        endcase
    end

    // Read-back mux for context save.
    always_comb begin
        rb_start = start_q[rb_depth];
        rb_count = cnt_q[rb_depth];
    end
endmodule

// File: rtl/hwloop_ctrl_chk.sv
// Property checker for hwloop_ctrl, bound to every instance.
module hwloop_ctrl_chk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ld_valid,
    input logic          ld_depth,
    input logic [CW-1:0] ld_count,
    input logic          fetch_valid,
    input logic          end_in,
    input logic          end_out,
    input logic [AW-1:0] seq_addr,
    input logic [AW-1:0] next_addr,
    input logic [AW-1:0] start_q [2],
    input logic [CW-1:0] cnt_q [2]
);
    localparam logic [CW-1:0] ONE = CW'(1);

    AST_INNER_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && end_in && cnt_q[0] > ONE) |-> next_addr == start_q[0]); // R3
    AST_INNER_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && end_in && cnt_q[0] > ONE && !(ld_valid && !ld_depth))
        |=> cnt_q[0] == $past(cnt_q[0]) - ONE); // R3
    AST_INNER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && end_in && !end_out && cnt_q[0] <= ONE) |-> next_addr == seq_addr); // R4
    AST_OUTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && end_in && end_out && cnt_q[0] > ONE && !(ld_valid && ld_depth))
        |=> $stable(cnt_q[1])); // R7
    AST_IDLE_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> next_addr == seq_addr); // R9
    AST_LOAD_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !ld_depth) |=> cnt_q[0] == $past(ld_count)); // R2
endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_valid    (ld_valid),
    .ld_depth    (ld_depth),
    .ld_count    (ld_count),
    .fetch_valid (fetch_valid),
    .end_in      (end_in),
    .end_out     (end_out),
    .seq_addr    (seq_addr),
    .next_addr   (next_addr),
    .start_q     (start_q),
    .cnt_q       (cnt_q)
);

// File: tb/hwloop_ctrl_tb.sv
// Directed bench for hwloop_ctrl: one task per scenario.
module hwloop_ctrl_tb;
    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_valid = 1'b0;
    logic          ld_depth = 1'b0;
    logic [AW-1:0] ld_start = '0;
    logic [CW-1:0] ld_count = '0;
    logic          fetch_valid = 1'b0;
    logic          end_in = 1'b0;
    logic          end_out = 1'b0;
    logic [AW-1:0] seq_addr = '0;
    logic [AW-1:0] next_addr;
    logic          rb_depth = 1'b0;
    logic [AW-1:0] rb_start;
    logic [CW-1:0] rb_count;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    hwloop_ctrl #(.AW(AW), .CW(CW)) u_dut (.*);

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Read back one depth (combinational) and compare.
    task automatic rb(input string req, input logic d, input logic [AW-1:0] s, input logic [CW-1:0] c);
        rb_depth = d;
        #1;
        chk(req, rb_start, s);
        chk(req, AW'(rb_count), AW'(c));
    endtask

    task automatic load(input logic d, input logic [AW-1:0] s, input logic [CW-1:0] c);
        ld_valid = 1'b1; ld_depth = d; ld_start = s; ld_count = c;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    // Present one packet, check next_addr in the same cycle, then clock it.
    task automatic pkt(input string req, input logic fv, input logic e0, input logic e1,
                       input logic [AW-1:0] sq, input logic [AW-1:0] exp);
        fetch_valid = fv; end_in = e0; end_out = e1; seq_addr = sq;
        #1;
        chk(req, next_addr, exp);
        @(negedge clk);
        fetch_valid = 1'b0; end_in = 1'b0; end_out = 1'b0;
    endtask

    task automatic t_reset;
        rb("R1", 1'b0, '0, '0);
        rb("R1", 1'b1, '0, '0);
        pkt("R1", 1'b1, 1'b1, 1'b1, 32'h44, 32'h44);
    endtask

    task automatic t_load;
        load(1'b1, 32'h900, 16'd7);
        load(1'b0, 32'h100, 16'd3);
        rb("R2", 1'b0, 32'h100, 16'd3);
        rb("R2", 1'b1, 32'h900, 16'd7);
    endtask

    task automatic t_inner;
        pkt("R3", 1'b1, 1'b1, 1'b0, 32'h120, 32'h100);
        rb("R3", 1'b0, 32'h100, 16'd2);
        pkt("R3", 1'b1, 1'b0, 1'b0, 32'h104, 32'h104);
        pkt("R3", 1'b1, 1'b1, 1'b0, 32'h120, 32'h100);
        pkt("R4", 1'b1, 1'b1, 1'b0, 32'h120, 32'h120);
        rb("R4", 1'b0, 32'h100, 16'd0);
    endtask

    task automatic t_zero;
        load(1'b0, 32'h300, 16'd0);
        pkt("R5", 1'b1, 1'b1, 1'b0, 32'h310, 32'h310);
        rb("R5", 1'b0, 32'h300, 16'd0);
    endtask

    task automatic t_outer_only;
        load(1'b1, 32'h500, 16'd2);
        pkt("R6", 1'b1, 1'b0, 1'b1, 32'h540, 32'h500);
        rb("R6", 1'b1, 32'h500, 16'd1);
        pkt("R6", 1'b1, 1'b0, 1'b1, 32'h540, 32'h540);
        rb("R6", 1'b1, 32'h500, 16'd0);
    endtask

    task automatic t_nested;
        load(1'b1, 32'h200, 16'd2);
        load(1'b0, 32'h210, 16'd2);
        pkt("R7", 1'b1, 1'b1, 1'b1, 32'h230, 32'h210);
        rb("R7", 1'b1, 32'h200, 16'd2);
        pkt("R8", 1'b1, 1'b1, 1'b1, 32'h230, 32'h200);
        rb("R8", 1'b1, 32'h200, 16'd1);
        rb("R8", 1'b0, 32'h210, 16'd0);
        load(1'b0, 32'h210, 16'd2);
        pkt("R7", 1'b1, 1'b1, 1'b1, 32'h230, 32'h210);
        pkt("R8", 1'b1, 1'b1, 1'b1, 32'h230, 32'h230);
        rb("R8", 1'b1, 32'h200, 16'd0);
    endtask

    task automatic t_idle;
        load(1'b0, 32'h600, 16'd4);
        pkt("R9", 1'b0, 1'b1, 1'b1, 32'h620, 32'h620);
        rb("R9", 1'b0, 32'h600, 16'd4);
    endtask

    task automatic t_collide;
        ld_valid = 1'b1; ld_depth = 1'b0; ld_start = 32'h700; ld_count = 16'd9;
        pkt("R10", 1'b1, 1'b1, 1'b0, 32'h640, 32'h600);
        ld_valid = 1'b0;
        rb("R10", 1'b0, 32'h700, 16'd9);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_inner();
        t_zero();
        t_outer_only();
        t_nested();
        t_idle();
        t_collide();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule